// File: doc/BRIEF.md
# Register-Cached Expression Stack Top

This block holds the upper end of an expression stack for an interpreter core built around stack operations. The two uppermost entries sit in registers, a top and a second entry, that feed an add/subtract unit directly. All deeper entries live in a single-port word memory outside the block, indexed by a stack pointer. The core issues one operation at a time: push a word, drop the top, or combine the two upper entries into one. When memory holds deeper entries, every operation that consumes an entry is followed by a read that refills the second register.

Each cached entry has a valid flag and a dirty flag. The dirty flag shows that the memory does not yet hold a copy of that entry. A push that displaces a dirty second entry writes it to memory in the same cycle. A clean second entry was loaded from memory, so a push simply moves the stack pointer past its copy without a write. The stack pointer plus one and minus one are held ready at all times, so the memory address never waits on an adder.

The controller has two states. `IDLE` accepts an operation. It moves to `REFILL` when a consuming operation leaves memory entries below the cache, and otherwise stays in `IDLE`. `REFILL` captures the read word into the second register and always returns to `IDLE`. `busy` is high in `REFILL`, and `done` pulses once for each accepted operation.

Top module: `stk_cache_top`

## Requirements
- R1: After reset both valid flags are 0, `sp` is 0, and `busy` and `done` are 0.
- R2: A push (op_code 0) places `op_data` in the top register and moves the previous top, if valid, into the second register. It completes with `done` one cycle after acceptance and without `busy`.
- R3: A push while both registers are valid and the second entry is dirty writes the second entry to memory at address `sp` in the acceptance cycle, then increments `sp`.
- R4: A push while both registers are valid and the second entry is clean (it was loaded from memory) issues no memory write but still increments `sp`.
- R5: Add (op_code 2) leaves second+top in the top register and subtract (op_code 3) leaves second−top, both modulo 2^W. The second register becomes invalid until refilled.
- R6: Pop (op_code 1) discards the top entry and moves the second entry into the top register.
- R7: A pop, add or subtract accepted while `sp` > 0 issues a read at `sp`−1 in the acceptance cycle. In the next cycle `busy` is 1. The read word is then loaded into the second register as a clean entry, `sp` decrements, and `done` follows two cycles after acceptance.
- R8: A pop, add or subtract accepted while `sp` is 0 completes in one cycle with no memory access.
- R9: An operation presented while `busy` is 1 is ignored: it produces no `done` and does not change the stack.
- R10: A pop with no valid entry, or an add or subtract with fewer than two valid entries, leaves the stack unchanged but still pulses `done` one cycle later.
- R11: Whenever `done` is 1, `tos_vld` is 1 exactly when the stack holds at least one entry, `nos_vld` is 1 exactly when it holds at least two, and `sp` equals the depth minus two (0 if the depth is below two).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 2 | 0 push, 1 pop, 2 add, 3 subtract |
| op_data | input | W | Word to push |
| busy | output | 1 | Refill read in flight; requests ignored |
| done | output | 1 | One-cycle pulse when an operation has taken effect |
| tos | output | W | Top register value |
| nos | output | W | Second register value |
| tos_vld | output | 1 | Top register holds an entry |
| nos_vld | output | 1 | Second register holds an entry |
| sp | output | AW | Count of entries below the second register |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | W | Word to write |
| mem_rdata | input | W | Read word, valid the cycle after a read access |

## Verification
The bench drives pushes, pops, adds and subtracts at several stack depths. Ops at shallow depth (below three entries) show the one-cycle path with no memory traffic. Ops at deeper depth show the serialized refill, and its value proves that the read came from the right address. A push that follows a refill separates clean entries from dirty ones by the memory-write count it leaves. Operations on an empty or single-entry stack, a subtract whose result wraps, an add that overflows, and a push held during `busy` probe the ignore rules and the modulo arithmetic.

// File: rtl/stk_cache_pkg.sv
package stk_cache_pkg;
    typedef enum logic [1:0] {
        OP_PUSH = 2'd0,
        OP_POP  = 2'd1,
        OP_ADD  = 2'd2,
        OP_SUB  = 2'd3
    } stk_op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REFILL = 1'b1
    } stk_state_e;
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] sp_up,
    output logic [AW-1:0] sp_dn
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] sp_q;

    // Both neighbours are always ready so the address mux never waits on an adder.
    assign sp_up = sp_q + ONE;
    assign sp_dn = sp_q - ONE;
    assign sp    = sp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sp_q <= '0;
        else if (inc)
            sp_q <= sp_up;
        else if (dec)
            sp_q <= sp_dn;
    end
endmodule

// File: rtl/stk_alu.sv
module stk_alu #(
    parameter int W = 16
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         sub,
    output logic [W-1:0] res
);
    always_comb begin
        if (sub)
            res = lhs - rhs;
        else
            res = lhs + rhs;
    end
endmodule

// File: rtl/stk_cache_top.sv
module stk_cache_top
    import stk_cache_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [1:0]    op_code,
    input  logic [W-1:0]  op_data,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  tos,
    output logic [W-1:0]  nos,
    output logic          tos_vld,
    output logic          nos_vld,
    output logic [AW-1:0] sp,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [W-1:0]  mem_wdata,
    input  logic [W-1:0]  mem_rdata
);
    stk_state_e    state_q, state_d;
    stk_op_e       opc;
    logic [W-1:0]  tos_q, nos_q, alu_res;
    logic          tos_v, nos_v, tos_dirty, nos_dirty;
    logic          done_q;
    logic [AW-1:0] sp_q, sp_up, sp_dn;
    logic          accept, do_push, do_cons, cons_ok, need_fill, spill, sp_inc, sp_dec;

    assign opc = stk_op_e'(op_code);

    stk_ptr #(.AW(AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .inc(sp_inc), .dec(sp_dec),
        .sp(sp_q), .sp_up(sp_up), .sp_dn(sp_dn)
    );

    stk_alu #(.W(W)) u_alu (
        .lhs(nos_q), .rhs(tos_q), .sub(opc == OP_SUB), .res(alu_res)
    );

    // Operation decode
    always_comb begin
        accept  = op_valid && (state_q == ST_IDLE);
        unique case (opc)
            OP_POP:        cons_ok = tos_v;
            OP_ADD, OP_SUB: cons_ok = tos_v && nos_v;
            default:       cons_ok = 1'b0;
        endcase
        do_push   = accept && (opc == OP_PUSH);
        do_cons   = accept && cons_ok;
        need_fill = do_cons && (sp_q != '0);
        spill     = do_push && tos_v && nos_v && nos_dirty;
        sp_inc    = do_push && tos_v && nos_v;
        sp_dec    = (state_q == ST_REFILL);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = need_fill ? ST_REFILL : ST_IDLE;
            ST_REFILL: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = (state_q == ST_REFILL);
        done      = done_q;
        tos       = tos_q;
        nos       = nos_q;
        tos_vld   = tos_v;
        nos_vld   = nos_v;
        sp        = sp_q;
        mem_en    = spill || need_fill;
        mem_we    = spill;
        mem_addr  = spill ? sp_q : sp_dn;
        mem_wdata = nos_q;
    end

    // Cached entries
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tos_q     <= '0;
            nos_q     <= '0;
            tos_v     <= 1'b0;
            nos_v     <= 1'b0;
            tos_dirty <= 1'b0;
            nos_dirty <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= (accept && !need_fill) || (state_q == ST_REFILL);
            if (state_q == ST_REFILL) begin
                nos_q     <= mem_rdata;
                nos_v     <= 1'b1;
                nos_dirty <= 1'b0;
            end else if (do_push) begin
                if (tos_v) begin
                    nos_q     <= tos_q;
                    nos_v     <= 1'b1;
                    nos_dirty <= tos_dirty;
                end
                tos_q     <= op_data;
                tos_v     <= 1'b1;
                tos_dirty <= 1'b1;
            end else if (do_cons) begin
                if (opc == OP_POP) begin
                    tos_q     <= nos_q;
                    tos_v     <= nos_v;
                    tos_dirty <= nos_dirty;
                end else begin
                    tos_q     <= alu_res;
                    tos_dirty <= 1'b1;
                end
                nos_v     <= 1'b0;
                nos_dirty <= 1'b0;
            end
        end
    end

    // Checks
    a_r3_sp_after_spill: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |=> (sp == $past(sp) + AW'(1)));
    a_r7_read_then_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> busy);
    a_r7_refill_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy && done && nos_vld && sp == $past(sp) - AW'(1)));
    a_r9_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mem_en);
    a_r11_nos_needs_tos: assert property (@(posedge clk) disable iff (!rst_n)
        nos_vld |-> tos_vld);
    a_r11_deep_means_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sp != '0) |-> nos_vld);
endmodule

// File: tb/stk_cache_top_test.sv
module stk_cache_top_test;
    localparam int W  = 16;
    localparam int AW = 6;

    typedef struct {
        logic [W-1:0] t;
        logic [W-1:0] n;
        bit           tv;
        bit           nv;
        int           sp;
        int           id;
    } exp_t;

    logic          clk = 0, rst_n = 0;
    logic          op_valid = 0;
    logic [1:0]    op_code = 0;
    logic [W-1:0]  op_data = 0;
    logic          busy, done, tos_vld, nos_vld, mem_en, mem_we;
    logic [W-1:0]  tos, nos, mem_wdata, mem_rdata;
    logic [AW-1:0] sp, mem_addr;

    logic [W-1:0] mem [0:(1<<AW)-1];
    logic [W-1:0] model [$];
    exp_t         expq [$];
    int checks = 0, fails = 0, wr_cnt = 0, op_id = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    stk_cache_top #(.W(W), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_data(op_data), .busy(busy), .done(done), .tos(tos), .nos(nos),
        .tos_vld(tos_vld), .nos_vld(nos_vld), .sp(sp), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_en && mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt = wr_cnt + 1;
        end
        if (mem_en && !mem_we)
            mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s op%0d: actual %0h expected %0h", req, op_id, act, exp);
        end
    endtask

    // Monitor: compares outputs against the scoreboard on every done pulse (R11)
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (expq.size() == 0) begin
                chk("R9 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk("R11 tos_vld", int'(tos_vld), int'(e.tv));
                chk("R11 nos_vld", int'(nos_vld), int'(e.nv));
                chk("R11 sp", int'(sp), e.sp);
                if (e.tv) chk("R2/R5/R6 tos", int'(tos), int'(e.t));
                if (e.nv) chk("R2/R7 nos", int'(nos), int'(e.n));
            end
        end
    end

    // Driver: updates the reference stack, queues expectations, drives one op
    task automatic run_op(input int code, input logic [W-1:0] d,
                          input int exp_wr, input bit inject);
        int pre, lat;
        bit cons, ok;
        exp_t e;
        pre  = model.size();
        cons = (code != 0);
        ok   = (code == 0) || (code == 1 && pre >= 1) || (code >= 2 && pre >= 2);
        if (ok) begin
            if (code == 0) model.push_back(d);
            else if (code == 1) void'(model.pop_back());
            else begin
                logic [W-1:0] a, b;
                b = model.pop_back();
                a = model.pop_back();
                model.push_back(code == 2 ? a + b : a - b);
            end
        end
        e.tv = model.size() >= 1;
        e.nv = model.size() >= 2;
        e.t  = e.tv ? model[model.size()-1] : '0;
        e.n  = e.nv ? model[model.size()-2] : '0;
        e.sp = (model.size() >= 2) ? model.size() - 2 : 0;
        e.id = op_id;
        expq.push_back(e);
        @(negedge clk);
        op_valid = 1; op_code = code[1:0]; op_data = d;
        @(negedge clk);
        lat = 1;
        op_valid = 0;
        // R7: busy in the cycle after a refill is issued; R2/R8: no busy otherwise
        chk("R7/R8 busy", int'(busy), int'(cons && ok && pre >= 3));
        if (inject) begin
            op_valid = 1; op_code = 2'd0; op_data = 16'h0999;   // R9
        end
        while (!done && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        op_valid = 0;
        chk("R7/R8 latency", lat, (cons && ok && pre >= 3) ? 2 : 1);
        chk("R3/R4 write count", wr_cnt, exp_wr);
        if (inject) begin
            @(negedge clk);
            chk("R9 ignored push no done", int'(done), 0);
            chk("R9 ignored push sp", int'(sp), e.sp);
        end
        op_id++;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 tos_vld", int'(tos_vld), 0);
        chk("R1 nos_vld", int'(nos_vld), 0);
        chk("R1 sp", int'(sp), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        rst_n = 1;
        run_op(1, 0, 0, 0);          // R10 pop on empty
        run_op(0, 16'd5, 0, 0);      // R2
        run_op(2, 0, 0, 0);          // R10 add with one entry
        run_op(0, 16'd7, 0, 0);      // R2
        run_op(3, 0, 0, 0);          // R5 R8 5-7 wraps to FFFE
        run_op(0, 16'd3, 0, 0);
        run_op(0, 16'd10, 1, 0);     // R3 spill FFFE
        run_op(0, 16'd20, 2, 0);     // R3 spill 3
        run_op(2, 0, 2, 0);          // R5 R7 refill 3
        run_op(0, 16'd4, 2, 0);      // R4 clean second, no write
        run_op(1, 0, 2, 0);          // R6 R7
        run_op(3, 0, 2, 1);          // R5 R7 R9
        run_op(1, 0, 2, 0);          // R6 R8
        run_op(0, 16'd8, 2, 0);      // R2 clean entry moves down
        run_op(0, 16'd9, 2, 0);      // R4 no write
        run_op(1, 0, 2, 0);          // R6 R7 refill FFFE
        run_op(2, 0, 2, 0);          // R5 FFFE+8 wraps to 6
        run_op(1, 0, 2, 0);          // R6 to empty
        run_op(1, 0, 2, 0);          // R10 pop on empty again
        repeat (2) @(negedge clk);
        chk("R11 scoreboard drained", expq.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule